// File: doc/BRIEF.md
# Radix-2 Decimation-in-Frequency FFT Address Generator

This block sequences an in-place radix-2 decimation-in-frequency FFT that keeps all of its points in one memory. After a start pulse it walks through log2(N) stages. In each stage a counter visits the N/2 butterflies of that stage. For every butterfly the block forms both operand addresses by splitting the counter at a position that depends on the stage and inserting one bit there: a 0 gives the upper operand and a 1 gives the lower. It also issues the twiddle-factor index and the stage number that go with that pair. The butterfly datapath sits outside the block. It reads both addresses, combines the two operands with the twiddle and writes the results back to the same addresses.

An enable input sets the pace. Each enabled cycle issues one pair, and a disabled cycle holds the outputs where they are. When the last butterfly of the last stage has been issued, a done flag rises and stays high. A DIF transform leaves its results in bit-reversed order, so the block also carries a combinational bit-reversal path. It maps a natural-order unload index to the memory address where that result is stored.

Top module: `fft_dif_addr_gen`

## Requirements
- R1: While reset is asserted and directly after it, valid and done are 0, and addr_a, addr_b, twiddle and stage are 0.
- R2: For a pair issued in stage s, with the counter value c (N/2 values, log2(N)-1 bits), the insertion position is p = log2(N)-1-s. addr_a is c with a 0 bit inserted at position p, so bits below p equal c's low p bits and the bits above p equal c's remaining bits. addr_b equals addr_a with bit p set.
- R3: A start pulse received while idle makes the block issue pairs with the counter running 0 to N/2-1 in stage 0, then again in each later stage up to log2(N)-1. Exactly one pair is issued per cycle in which enable is high. The pair appears on the outputs, with valid=1, in the cycle after that enabled clock edge.
- R4: The twiddle index of a pair equals (c << s) taken modulo N/2.
- R5: After a clock edge at which enable is low, valid is 0 and addr_a, addr_b and twiddle keep their previous values.
- R6: done rises in the same cycle in which the last pair (stage log2(N)-1, counter N/2-1) is valid. It stays high with no further valid pairs until the next start.
- R7: A start pulse that arrives while a transform is in progress is ignored, and the sequence continues unchanged.
- R8: unload_addr is the bit-reversal of unload_idx (bit i of the output is bit log2(N)-1-i of the input), available combinationally.
- R9: A start pulse received while done is high clears done at the next edge and restarts the sequence from stage 0, counter 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transform when idle |
| enable | input | 1 | Issue one pair at this edge while running |
| unload_idx | input | log2(N) | Natural-order result index |
| addr_a | output | log2(N) | Upper operand address |
| addr_b | output | log2(N) | Lower operand address |
| twiddle | output | log2(N)-1 | Twiddle-factor index |
| stage | output | clog2(log2(N)+1) | Stage number of the issued pair |
| valid | output | 1 | A new pair is on the outputs |
| done | output | 1 | All stages issued (sticky until start) |
| unload_addr | output | log2(N) | Bit-reversed memory address for unload_idx |

## Verification
Several properties are checked on every cycle. Each valid pair must differ in exactly one bit, with that bit clear in addr_a. The stage number must stay in range. The twiddle index must have zero low bits up to the stage number. A disabled edge must leave the outputs frozen with valid low. The done flag must be sticky and must cut off further pairs. Other behaviour can only be shown by the scoreboard scenarios. These are the exact order of pairs across stages, the twiddle values themselves, the alignment of done with the final pair, the ignored start during a run, restart after done, and the bit-reversed unload mapping.

// File: rtl/fft_dif_addr_gen.sv
module fft_dif_addr_gen #(
  parameter int POINTS    = 4096,
  parameter bit UNLOAD_EN = 1'b1,
  localparam int AW = $clog2(POINTS),
  localparam int HW = AW - 1,
  localparam int SW = $clog2(AW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          enable,
  input  logic [AW-1:0] unload_idx,
  output logic [AW-1:0] addr_a,
  output logic [AW-1:0] addr_b,
  output logic [HW-1:0] twiddle,
  output logic [SW-1:0] stage,
  output logic          valid,
  output logic          done,
  output logic [AW-1:0] unload_addr
);

  logic          busy;
  logic [HW-1:0] cnt;
  logic [SW-1:0] stage_q;

  logic [AW-1:0] cnt_w, ins_bit, lo_mask, base;
  logic [HW-1:0] tw_next;
  logic          last_cnt, last_stage;

  assign cnt_w      = {1'b0, cnt};
  assign ins_bit    = AW'(1) << (SW'(HW) - stage_q);
  assign lo_mask    = ins_bit - AW'(1);
  assign base       = ((cnt_w & ~lo_mask) << 1) | (cnt_w & lo_mask);
  assign tw_next    = cnt << stage_q;
  assign last_cnt   = &cnt;
  assign last_stage = (stage_q == SW'(HW));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      stage_q <= '0;
      addr_a  <= '0;
      addr_b  <= '0;
      twiddle <= '0;
      stage   <= '0;
      valid   <= 1'b0;
      done    <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (start && !busy) begin
        busy    <= 1'b1;
        cnt     <= '0;
        stage_q <= '0;
        done    <= 1'b0;
      end else if (busy && enable) begin
        valid   <= 1'b1;
        addr_a  <= base;
        addr_b  <= base | ins_bit;
        twiddle <= tw_next;
        stage   <= stage_q;
        cnt     <= cnt + HW'(1);
        if (last_cnt) begin
          if (last_stage) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            stage_q <= stage_q + SW'(1);
          end
        end
      end
    end
  end

  generate
    if (UNLOAD_EN) begin : g_unload
      for (genvar i = 0; i < AW; i++) begin : g_rev
        assign unload_addr[i] = unload_idx[AW-1-i];
      end
    end else begin : g_no_unload
      assign unload_addr = unload_idx;
    end
  endgenerate

endmodule

module fft_dif_addr_chk #(
  parameter int POINTS = 4096,
  localparam int AW = $clog2(POINTS),
  localparam int HW = AW - 1,
  localparam int SW = $clog2(AW + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          enable,
  input logic [AW-1:0] addr_a,
  input logic [AW-1:0] addr_b,
  input logic [HW-1:0] twiddle,
  input logic [SW-1:0] stage,
  input logic          valid,
  input logic          done
);

  p_pair_one_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ($onehot(addr_a ^ addr_b) && ((addr_a & (addr_a ^ addr_b)) == '0)));

  p_stage_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (stage < SW'(AW)));

  p_twiddle_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((twiddle & ((HW'(1) << stage) - HW'(1))) == '0));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!valid && $stable(addr_a) && $stable(addr_b) && $stable(twiddle)));

  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && !valid));

  p_start_clears_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> !done);

endmodule

bind fft_dif_addr_gen fft_dif_addr_chk #(.POINTS(POINTS)) u_fft_dif_addr_chk (.*);

// File: tb/test_fft_dif_addr_gen.sv
`timescale 1ns/100ps
module test_fft_dif_addr_gen;
  localparam int P    = 32;
  localparam int AW   = 5;
  localparam int HW   = 4;
  localparam int SW   = 3;
  localparam int HALF = P / 2;
  localparam int NPR  = HALF * AW;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [AW-1:0] b;
    logic [HW-1:0] t;
    logic [SW-1:0] s;
    logic          last;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, enable = 1'b0;
  logic [AW-1:0] unload_idx = '0;
  logic [AW-1:0] addr_a, addr_b, unload_addr;
  logic [HW-1:0] twiddle;
  logic [SW-1:0] stage;
  logic valid, done;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  item_t sb[$];
  logic [AW-1:0] prev_a = '0, prev_b = '0;
  logic [HW-1:0] prev_t = '0;
  logic [7:0] lfsr = 8'h5A;

  always #2.5 clk = ~clk;

  fft_dif_addr_gen #(.POINTS(P)) i_fft_dif_addr_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .enable(enable),
    .unload_idx(unload_idx), .addr_a(addr_a), .addr_b(addr_b),
    .twiddle(twiddle), .stage(stage), .valid(valid), .done(done),
    .unload_addr(unload_addr));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Monitor: pops expected pairs when valid, checks hold otherwise
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R6 unexpected pair", int'(addr_a), -1);
        end else begin
          item_t e;
          e = sb.pop_front();
          check(addr_a == e.a, "R2 addr_a", int'(addr_a), int'(e.a));
          check(addr_b == e.b, "R2 addr_b", int'(addr_b), int'(e.b));
          check(twiddle == e.t, "R4 twiddle", int'(twiddle), int'(e.t));
          check(stage == e.s, "R3 stage", int'(stage), int'(e.s));
          check(done == e.last, "R6 done with last pair", int'(done), int'(e.last));
        end
      end else begin
        check(addr_a == prev_a && addr_b == prev_b && twiddle == prev_t,
              "R5 hold", int'(addr_a), int'(prev_a));
      end
      prev_a = addr_a;
      prev_b = addr_b;
      prev_t = twiddle;
    end
  end

  // Driver: queue expected pairs then run with an enable pattern
  task automatic run_fft(input int pat);
    int issued = 0;
    bit en;
    for (int s = 0; s < AW; s++) begin
      for (int j = 0; j < HALF; j++) begin
        item_t e;
        int pos = AW - 1 - s;
        int a = ((j >> pos) << (pos + 1)) + (j % (1 << pos));
        e.a = AW'(a);
        e.b = AW'(a + (1 << pos));
        e.t = HW'((j << s) % HALF);
        e.s = SW'(s);
        e.last = (s == AW - 1) && (j == HALF - 1);
        sb.push_back(e);
      end
    end
    start = 1'b1;
    enable = 1'b0;
    @(posedge clk); #1;
    start = 1'b0;
    if (pat != 0) check(done == 1'b0, "R9 done cleared by start", int'(done), 0);
    while (issued < NPR) begin
      case (pat)
        0: en = 1'b1;
        1: en = issued[0] ? 1'b1 : ~en;
        default: begin
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          en = lfsr[0] | lfsr[2];
        end
      endcase
      enable = en;
      // R7: a start pulse in the middle of a run must be ignored
      start = (pat == 1 && issued == NPR / 2);
      @(posedge clk); #1;
      if (en) issued++;
    end
    start = 1'b0;
    enable = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(done == 1'b1, "R6 done sticky", int'(done), 1);
    check(valid == 1'b0, "R6 no pair after done", int'(valid), 0);
    check(sb.size() == 0, "R3 all pairs issued", sb.size(), 0);
    enable = 1'b0;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(valid == 0 && done == 0, "R1 reset flags", int'({valid, done}), 0);
    check(addr_a == 0 && addr_b == 0 && twiddle == 0 && stage == 0,
          "R1 reset outputs", int'(addr_b), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(valid == 0 && done == 0, "R1 after reset", int'({valid, done}), 0);

    for (int i = 0; i < P; i++) begin
      int r = 0;
      for (int k = 0; k < AW; k++) r = (r << 1) | ((i >> k) & 1);
      unload_idx = AW'(i);
      #0.5;
      check(unload_addr == AW'(r), "R8 bit-reversed unload", int'(unload_addr), r);
    end

    run_fft(0);
    run_fft(1);
    run_fft(2);
    wrap_up();
  end

  initial begin
    #(5.0 * 150000);
    check(1'b0, "watchdog", 0, 1);
    wrap_up();
  end
endmodule